// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This block carries out one two-word "load into accumulator" instruction. The first word, at the program counter, holds the addressing mode in its low four bits. The second word, at PC+1, holds the address field. The unit works out the effective address for one of nine addressing modes, fetches the operand, and writes it into its accumulator. It then reports the effective address, the loaded value, a one-cycle `done`, and the updated program counter and general register.

The unit keeps three architectural registers: a program counter, a general register and an index register. It also reads a word memory held inside the block, through a single port that makes one access per cycle. Each mode takes the number of memory accesses it needs and no more, so the cycles per instruction depend on the mode. The autoincrement and autodecrement modes also step the general register.

While the unit is idle, a host writes the memory through a write port and preloads the three registers with a load strobe. The host then pulses `start` and waits for `done`.

Top module: `addr_mode_unit`

## Requirements
- R1: After reset, `pc`, `r1`, `ac` and `ea` read zero, and `busy`, `done` and `err` are low.
- R2: The mode comes from bits [3:0] of the word at PC; the upper bits of that word are ignored. The address field is the word at PC+1. Codes: 0 direct, 1 immediate, 2 indirect, 3 relative, 4 indexed, 5 register, 6 register-indirect, 7 autoincrement, 8 autodecrement.
- R3: Immediate mode reports PC+1 as the effective address and loads the address field itself into `ac`.
- R4: Direct mode uses the address field as the effective address. Indirect mode reads the word at the address field and uses that word as the effective address. Both load the word found at the effective address.
- R5: Relative mode uses PC+2 plus the field, and indexed mode uses the index register plus the field. Both sums wrap modulo 2^DW, so a field with its top bit set acts as a negative offset.
- R6: Register mode loads the general register into `ac` and reports it on `ea`. Register-indirect mode uses the general register as the effective address.
- R7: Autoincrement uses the general register as the effective address and then leaves it one higher. Autodecrement first lowers the general register by one and uses the lowered value as the effective address.
- R8: Codes 9 to 15 raise `err` together with `done`, leave `ac` unchanged and report `ea` as zero. `err` is low on completion of any valid mode.
- R9: Every completed instruction, including a faulty one, leaves `pc` exactly 2 higher.
- R10: `done` is a single-cycle pulse. It is high after the 2nd rising edge following the edge that samples `start` for immediate, register and unused codes, after the 4th for indirect, and after the 3rd for all other modes. `busy` is high from the accepting edge until the finishing edge.
- R11: `start` asserted while `busy` is high has no effect: there is no extra `done` and the result does not change.
- R12: `ld_regs` while idle loads `pc`, the general register and the index register from their init inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction at `pc` (accepted when idle) |
| ld_regs | input | 1 | Load the three registers from the init inputs (idle only) |
| pc_init | input | DW | Program counter load value |
| r1_init | input | DW | General register load value |
| xr_init | input | DW | Index register load value |
| mem_we | input | 1 | Memory write strobe |
| mem_waddr | input | DW | Memory write address |
| mem_wdata | input | DW | Memory write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last instruction had an unused mode code |
| ea | output | DW | Effective address of the last instruction |
| ac | output | DW | Accumulator |
| pc | output | DW | Program counter |
| r1 | output | DW | General register |

## Verification
The bench builds the unit with DW = 16 and DEPTH = 4096. This gives twelve real address bits, so the register and memory values of a worked example with hexadecimal addresses up to 0x950 fit as written. It also lets a 16-bit field such as 0xFFF0 act as a negative offset for the relative and indexed sums. With DEPTH below 2^DW, the range-checked memory variant is the one under test. The cycle model predicts `done` and `busy` on every clock, so the per-mode access counts are checked, and so is a second `start` raised during an instruction.

// File: rtl/amu_pkg.sv
package amu_pkg;

   typedef enum logic [3:0] {
      AM_DIRECT   = 4'd0,
      AM_IMMED    = 4'd1,
      AM_INDIR    = 4'd2,
      AM_RELATIVE = 4'd3,
      AM_INDEXED  = 4'd4,
      AM_REG      = 4'd5,
      AM_REGIND   = 4'd6,
      AM_AUTOINC  = 4'd7,
      AM_AUTODEC  = 4'd8
   } amu_mode_e;

   localparam logic [3:0] AM_LAST_VALID = 4'd8;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_MODE = 3'd1,
      ST_ADDR = 3'd2,
      ST_IND  = 3'd3,
      ST_OPER = 3'd4
   } amu_state_e;

   function automatic logic amu_mode_ok(input logic [3:0] code);
      return code <= AM_LAST_VALID;
   endfunction

endpackage

// File: rtl/amu_mem.sv
module amu_mem #(
   parameter int DW    = 16,
   parameter int DEPTH = 1024
) (
   input  logic          clk,
   input  logic          we,
   input  logic [DW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit FULL_SPACE = (longint'(DEPTH) == (longint'(1) << DW));

   initial begin
      assert (DEPTH >= 2) else $error("amu_mem: DEPTH must be at least 2");
      assert (longint'(DEPTH) <= (longint'(1) << DW))
         else $error("amu_mem: DEPTH exceeds the DW address space");
   end

   logic [DW-1:0] store [DEPTH];

   generate
      if (FULL_SPACE) begin : g_full
         // every address word maps to a location
         always_ff @(posedge clk) begin
            if (we) store[waddr[AW-1:0]] <= wdata;
         end
         assign rdata = store[raddr[AW-1:0]];
      end else begin : g_ranged
         localparam logic [DW:0] LIMIT = DEPTH[DW:0];
         logic wr_in, rd_in;
         assign wr_in = ({1'b0, waddr} < LIMIT);
         assign rd_in = ({1'b0, raddr} < LIMIT);
         always_ff @(posedge clk) begin
            if (we && wr_in) store[waddr[AW-1:0]] <= wdata;
         end
         assign rdata = rd_in ? store[raddr[AW-1:0]] : '0;
      end
   endgenerate

endmodule

// File: rtl/amu_ea_calc.sv
module amu_ea_calc
   import amu_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [3:0]    mode,
   input  logic [DW-1:0] pc,
   input  logic [DW-1:0] r1,
   input  logic [DW-1:0] xr,
   input  logic [DW-1:0] field,
   output logic [DW-1:0] ea
);
   localparam logic [DW-1:0] ONE = DW'(1);
   localparam logic [DW-1:0] TWO = DW'(2);

   initial begin
      assert (DW >= 4) else $error("amu_ea_calc: DW must hold the mode field");
   end

   always_comb begin
      case (mode)
         AM_DIRECT:   ea = field;
         AM_INDIR:    ea = field;            // pointer address, replaced after the extra read
         AM_IMMED:    ea = pc + ONE;
         AM_RELATIVE: ea = pc + TWO + field;
         AM_INDEXED:  ea = xr + field;
         AM_REG:      ea = r1;
         AM_REGIND:   ea = r1;
         AM_AUTOINC:  ea = r1;
         AM_AUTODEC:  ea = r1 - ONE;
         default:     ea = '0;
      endcase
   end

endmodule

// File: rtl/amu_regs.sv
module amu_regs #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [DW-1:0] pc_in,
   input  logic [DW-1:0] r1_in,
   input  logic [DW-1:0] xr_in,
   input  logic          pc_adv,
   input  logic          r1_inc,
   input  logic          r1_dec,
   output logic [DW-1:0] pc,
   output logic [DW-1:0] r1,
   output logic [DW-1:0] xr
);
   localparam logic [DW-1:0] ONE = DW'(1);
   localparam logic [DW-1:0] TWO = DW'(2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= '0;
         r1 <= '0;
         xr <= '0;
      end else if (ld) begin
         pc <= pc_in;
         r1 <= r1_in;
         xr <= xr_in;
      end else begin
         if (pc_adv) pc <= pc + TWO;
         if (r1_inc) r1 <= r1 + ONE;
         else if (r1_dec) r1 <= r1 - ONE;
      end
   end

   assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ld) && (pc != $past(pc))) |-> (pc == $past(pc) + TWO));

   assert_r1_unit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ld) && (r1 != $past(r1))) |-> ((r1 == $past(r1) + ONE) || (r1 == $past(r1) - ONE)));

endmodule

// File: rtl/addr_mode_unit.sv
module addr_mode_unit
   import amu_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEPTH = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          ld_regs,
   input  logic [DW-1:0] pc_init,
   input  logic [DW-1:0] r1_init,
   input  logic [DW-1:0] xr_init,
   input  logic          mem_we,
   input  logic [DW-1:0] mem_waddr,
   input  logic [DW-1:0] mem_wdata,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [DW-1:0] ea,
   output logic [DW-1:0] ac,
   output logic [DW-1:0] pc,
   output logic [DW-1:0] r1
);
   localparam logic [DW-1:0] ONE = DW'(1);

   initial begin
      assert (DW >= 4 && DW <= 32) else $error("addr_mode_unit: DW out of range");
   end

   amu_state_e    state_q;
   logic [3:0]    mode_q;
   logic [DW-1:0] field_q, ea_q, ac_q;
   logic          done_q, err_q;

   logic [DW-1:0] pc_q, r1_q, xr_q;
   logic [DW-1:0] mem_ra, mem_rd, ea_nx;
   logic          finish, fin_err, r1_inc, r1_dec, ld_ok;

   assign ld_ok = ld_regs && (state_q == ST_IDLE);

   amu_regs #(.DW(DW)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (ld_ok),
      .pc_in  (pc_init),
      .r1_in  (r1_init),
      .xr_in  (xr_init),
      .pc_adv (finish),
      .r1_inc (r1_inc),
      .r1_dec (r1_dec),
      .pc     (pc_q),
      .r1     (r1_q),
      .xr     (xr_q)
   );

   amu_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (mem_ra),
      .rdata (mem_rd)
   );

   // during ST_ADDR the field is on the read port this very cycle
   amu_ea_calc #(.DW(DW)) u_ea (
      .mode  (mode_q),
      .pc    (pc_q),
      .r1    (r1_q),
      .xr    (xr_q),
      .field (mem_rd),
      .ea    (ea_nx)
   );

   // one memory access per cycle: address chosen by sequencer state
   always_comb begin
      mem_ra  = pc_q;
      finish  = 1'b0;
      fin_err = 1'b0;
      r1_inc  = 1'b0;
      r1_dec  = 1'b0;
      case (state_q)
         ST_MODE: mem_ra = pc_q;
         ST_ADDR: begin
            mem_ra = pc_q + ONE;
            if (!amu_mode_ok(mode_q)) begin
               finish  = 1'b1;
               fin_err = 1'b1;
            end else if (mode_q == AM_IMMED || mode_q == AM_REG) begin
               finish = 1'b1;
            end
            r1_dec = (mode_q == AM_AUTODEC);
         end
         ST_IND:  mem_ra = field_q;
         ST_OPER: begin
            mem_ra = ea_q;
            finish = 1'b1;
            r1_inc = (mode_q == AM_AUTOINC);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= '0;
         field_q <= '0;
         ea_q    <= '0;
         ac_q    <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= finish;
         if (finish) err_q <= fin_err;
         case (state_q)
            ST_IDLE: if (start) state_q <= ST_MODE;
            ST_MODE: begin
               mode_q  <= mem_rd[3:0];
               state_q <= ST_ADDR;
            end
            ST_ADDR: begin
               field_q <= mem_rd;
               ea_q    <= fin_err ? '0 : ea_nx;
               if (mode_q == AM_IMMED) ac_q <= mem_rd;
               if (mode_q == AM_REG)   ac_q <= r1_q;
               if (finish)                 state_q <= ST_IDLE;
               else if (mode_q == AM_INDIR) state_q <= ST_IND;
               else                        state_q <= ST_OPER;
            end
            ST_IND: begin
               ea_q    <= mem_rd;
               state_q <= ST_OPER;
            end
            ST_OPER: begin
               ac_q    <= mem_rd;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign done = done_q;
   assign err  = err_q;
   assign ea   = ea_q;
   assign ac   = ac_q;
   assign pc   = pc_q;
   assign r1   = r1_q;

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   assert_err_keeps_ac_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && err_q) |-> (ac_q == $past(ac_q)));

   assert_immed_ea_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !err_q && mode_q == AM_IMMED) |-> (ea_q == pc_q - ONE));

   assert_idle_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (state_q == ST_IDLE || state_q == ST_MODE));

endmodule

// File: tb/addr_mode_unit_tb.sv
`timescale 1ns/1ps
module addr_mode_unit_tb;
   localparam int DW    = 16;
   localparam int DEPTH = 4096;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          ld_regs = 1'b0;
   logic [DW-1:0] pc_init = '0, r1_init = '0, xr_init = '0;
   logic          mem_we = 1'b0;
   logic [DW-1:0] mem_waddr = '0, mem_wdata = '0;
   logic          busy, done, err;
   logic [DW-1:0] ea, ac, pc, r1;

   always #2.5 clk = ~clk;

   addr_mode_unit #(.DW(DW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ld_regs(ld_regs),
      .pc_init(pc_init), .r1_init(r1_init), .xr_init(xr_init),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .busy(busy), .done(done), .err(err), .ea(ea), .ac(ac), .pc(pc), .r1(r1)
   );

   int vectors = 0;
   int miscompares = 0;

   // behavioural reference state
   logic [15:0] mdl [int];
   logic [15:0] m_pc = 0, m_r1 = 0, m_xr = 0, m_ac = 0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] rd(input logic [15:0] a);
      if (int'(a) < DEPTH && mdl.exists(int'(a))) return mdl[int'(a)];
      return 16'h0;
   endfunction

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      mem_we = 1'b1; mem_waddr = a; mem_wdata = d;
      @(negedge clk);
      mem_we = 1'b0;
      mdl[int'(a)] = d;
   endtask

   task automatic load(input logic [15:0] p, input logic [15:0] g, input logic [15:0] x);
      @(negedge clk);
      ld_regs = 1'b1; pc_init = p; r1_init = g; xr_init = x;
      @(negedge clk);
      ld_regs = 1'b0;
      m_pc = p; m_r1 = g; m_xr = x;
      chk("R12", "pc load", pc, p);
      chk("R12", "r1 load", r1, g);
   endtask

   task automatic exec(input logic [3:0] code, input bit poke, input string req);
      logic [15:0] f, ea_e, op_e, r1_e, ac_e;
      int lat;
      bit er;
      wr(m_pc, {12'h5C3, code});       // upper bits are noise (R2)
      f = rd(m_pc + 16'd1);
      er = 0; r1_e = m_r1; op_e = 0; ea_e = 0; lat = 3;
      case (code)
         4'd0: begin ea_e = f; op_e = rd(ea_e); end
         4'd1: begin ea_e = m_pc + 16'd1; op_e = f; lat = 2; end
         4'd2: begin ea_e = rd(f); op_e = rd(ea_e); lat = 4; end
         4'd3: begin ea_e = m_pc + 16'd2 + f; op_e = rd(ea_e); end
         4'd4: begin ea_e = m_xr + f; op_e = rd(ea_e); end
         4'd5: begin ea_e = m_r1; op_e = m_r1; lat = 2; end
         4'd6: begin ea_e = m_r1; op_e = rd(ea_e); end
         4'd7: begin ea_e = m_r1; op_e = rd(ea_e); r1_e = m_r1 + 16'd1; end
         4'd8: begin ea_e = m_r1 - 16'd1; op_e = rd(ea_e); r1_e = m_r1 - 16'd1; end
         default: begin er = 1; lat = 2; end
      endcase
      ac_e = er ? m_ac : op_e;
      @(negedge clk);
      start = 1'b1;
      for (int k = 0; k <= lat; k++) begin
         @(negedge clk);
         if (k == 0) start = 1'b0;
         if (poke && k == 1) start = 1'b1;   // R11: ignored while busy
         if (poke && k == 2) start = 1'b0;
         chk("R10", "done", done, (k == lat));
         chk("R10", "busy", busy, (k < lat));
         if (k == lat) begin
            chk(req, "ea", ea, ea_e);
            chk(req, "ac", ac, ac_e);
            chk("R7", "r1", r1, r1_e);
            chk("R8", "err", err, er);
            chk("R9", "pc", pc, m_pc + 16'd2);
         end
      end
      @(negedge clk);
      chk("R11", "no extra done", done, 0);
      chk("R11", "no extra busy", busy, 0);
      m_pc = m_pc + 16'd2; m_r1 = r1_e; m_ac = ac_e;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "pc", pc, 0);
      chk("R1", "r1", r1, 0);
      chk("R1", "ac", ac, 0);
      chk("R1", "ea", ea, 0);
      chk("R1", "busy", busy, 0);
      chk("R1", "done", done, 0);
      chk("R1", "err", err, 0);
      rst_n = 1'b1;

      // worked example memory image
      wr(16'h0351, 16'h0400);
      wr(16'h0400, 16'h0833);
      wr(16'h0833, 16'h0900);
      wr(16'h0834, 16'h0950);
      wr(16'h0900, 16'h0456);
      wr(16'h0752, 16'h0189);
      wr(16'h0525, 16'h0735);

      load(16'h0350, 16'h0834, 16'h0125); exec(4'd0, 0, "R4");   // direct: 833
      load(16'h0350, 16'h0834, 16'h0125); exec(4'd1, 1, "R3");   // immediate: 400
      load(16'h0350, 16'h0834, 16'h0125); exec(4'd2, 0, "R4");   // indirect: 900
      load(16'h0350, 16'h0834, 16'h0125); exec(4'd3, 1, "R5");   // relative: 189
      load(16'h0350, 16'h0834, 16'h0125); exec(4'd4, 0, "R5");   // indexed: 735
      load(16'h0350, 16'h0834, 16'h0125); exec(4'd5, 0, "R6");   // register: 834
      load(16'h0350, 16'h0834, 16'h0125); exec(4'd6, 1, "R6");   // reg-indirect: 950
      load(16'h0350, 16'h0834, 16'h0125); exec(4'd7, 0, "R7");   // autoinc: 950, r1 835
      load(16'h0350, 16'h0834, 16'h0125); exec(4'd8, 1, "R7");   // autodec: 900, r1 833

      // unused code keeps ac (R8), then chained instructions without reload (R9)
      load(16'h0350, 16'h0834, 16'h0125);
      exec(4'd12, 1, "R8");
      wr(16'h0353, 16'h0834);
      exec(4'd0, 0, "R4");
      wr(16'h0355, 16'h0000);
      exec(4'd15, 0, "R8");
      exec(4'd7, 0, "R7");
      exec(4'd7, 0, "R7");

      // negative offsets wrap modulo 2^16 (R5)
      wr(16'h0342, 16'h1234);
      wr(16'h0000, 16'h0BAD);
      wr(16'h0351, 16'hFFF0);
      load(16'h0350, 16'h0001, 16'h0010); exec(4'd3, 0, "R5");
      load(16'h0350, 16'h0001, 16'h0010); exec(4'd4, 0, "R5");
      load(16'h0350, 16'h0000, 16'h0010); exec(4'd8, 0, "R7");  // r1 wraps to FFFF, reads zero

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule